// File: doc/BRIEF.md
# Systolic Four-Tap Convolution Array

This block computes a four-tap finite convolution with a chain of four processing elements that each keep one weight. Input samples march through the chain in one direction, one element per clock, while partial sums march the opposite way, entering the far end as zero and picking up one weighted sample in each element they pass. Every hop is a register-to-register link. Because the two streams move against each other, a sample meets a given partial sum only if samples are spaced two cycles apart. For that reason the caller feeds one sample, then an idle slot, then the next sample.

Weights are loaded serially: while `loadEn` is high, each cycle shifts one weight into the chain. The whole array holds still for as long as loading lasts. In any cycle that is not a load cycle, the array advances. That cycle injects `sampleIn` if `sampleValid` is high, and injects a zero otherwise. The sum that leaves the array then appears on `result`. `resultValid` marks the sums that were built from four real samples.

Top module: `conv_systolic`

## Requirements
- R1: A synchronous reset clears every sample, partial-sum and weight register. In the cycle after reset is released, `result` is 0 and `resultValid` is 0.
- R2: Each cycle with `loadEn` high shifts `weightIn` into the weight chain. After four load cycles carrying v1, v2, v3, v4 in that order, w1=v1, w2=v2, w3=v3 and w4=v4.
- R3: While `loadEn` is high the array is frozen. `result` holds its value and `resultValid` is 0 in the cycle that follows each load cycle. `sampleIn` and `sampleValid` have no effect.
- R4: Count only the advancing (non-load) cycles. Let x[t] be the value injected in advancing cycle t. After cycle t, `result` equals w1·x[t-6] + w2·x[t-4] + w3·x[t-2] + w4·x[t]. Each term uses the weight that was held when the element processed it. Values injected before the last reset count as zero.
- R5: Suppose samples s(0), s(1), ... are fed on alternate advancing cycles, with idle slots between them. Then the result after s(i+3) is injected equals w1·s(i) + w2·s(i+1) + w3·s(i+2) + w4·s(i+3).
- R6: `resultValid` is 1 after advancing cycle t exactly when `sampleValid` was 1 in cycle t and in advancing cycles t-2, t-4 and t-6. For alternating feed, the first valid result therefore comes 7 advancing cycles after the first sample.
- R7: In an advancing cycle with `sampleValid` low, a zero is injected and the value on `sampleIn` has no effect on any result.
- R8: Samples and weights are 8-bit two's complement, and results are 20-bit two's complement. Products and sums are signed, with no overflow at the extremes (four products of -128·-128).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | High: shift `weightIn` into the weight chain and freeze the array |
| weightIn | input | 8 | Signed weight value for serial loading |
| sampleValid | input | 1 | High: `sampleIn` is a real sample for this slot |
| sampleIn | input | 8 | Signed input sample |
| result | output | 20 | Signed partial sum leaving the array |
| resultValid | output | 1 | High when `result` is built from four real samples |

## Verification
An impulse (a single 1 surrounded by idle slots) is used against distinct weights. It shows whether each weight landed in the right element, because w4, w3, w2 and w1 must appear on `result` two cycles apart, in that order. A ramp of samples fed on alternate cycles checks the convolution itself and the exact cycle of the first valid result. Extreme negative samples and weights check signed growth. Back-to-back samples with no idle slots exercise the general injection formula and the valid rule outside the intended feed. A weight reload in the middle of a stream, with garbage on the sample pins, separates true freezing from a design that keeps advancing or that leaks idle-slot data into the sums.

// File: rtl/conv_pkg.sv
`timescale 1ns/1ps
package conv_pkg;
  // Strobes from control to datapath, one set per clock.
  typedef struct packed {
    logic advance;      // move samples and sums one element
    logic shiftWeight;  // shift one weight into the chain
    logic takeSample;   // inject the sample input instead of a zero
  } convStrobes_t;
endpackage

// File: rtl/conv_pe.sv
`timescale 1ns/1ps
module conv_pe #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic signed [DATA_W-1:0] weight,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [SUM_W-1:0]  yIn,
  output logic signed [DATA_W-1:0] xOut,
  output logic signed [SUM_W-1:0]  yOut
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] xReg;
  logic signed [SUM_W-1:0]  yReg;
  logic signed [PROD_W-1:0] prod;

  assign prod = weight * xIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg <= '0;
      yReg <= '0;
    end else if (advance) begin
      xReg <= xIn;
      yReg <= yIn + SUM_W'(prod);
    end
  end

  assign xOut = xReg;
  assign yOut = yReg;

  // R7: an idle (zero) slot passes the partial sum through unchanged
  a_r7_bubble_passes: assert property (@(posedge clk) disable iff (rst)
    (advance && xIn == '0) |=> (yOut == $past(yIn)));

  // R3: a frozen element keeps both of its registers
  a_r3_pe_frozen: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(yOut) && $stable(xOut)));
endmodule

// File: rtl/conv_datapath.sv
`timescale 1ns/1ps
module conv_datapath import conv_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 20,
  parameter int TAPS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  convStrobes_t             strobes,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic signed [DATA_W-1:0] weightIn,
  output logic signed [SUM_W-1:0]  result
);
  // sampleLink[k] enters element k; sumLink[k] leaves element k toward the output
  logic signed [DATA_W-1:0] sampleLink [TAPS+1];
  logic signed [SUM_W-1:0]  sumLink    [TAPS+1];
  logic signed [DATA_W-1:0] wChain     [TAPS];   // wChain[j] holds weight w(j+1)

  assign sampleLink[0] = strobes.takeSample ? sampleIn : '0;
  assign sumLink[TAPS] = '0;

  // Serial weight chain: newest value enters at the top, oldest ends at w1
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TAPS; j++) wChain[j] <= '0;
    end else if (strobes.shiftWeight) begin
      for (int j = 0; j < TAPS - 1; j++) wChain[j] <= wChain[j+1];
      wChain[TAPS-1] <= weightIn;
    end
  end

  // Element k sits k hops from the sample entry and sees weight w(TAPS-k)
  for (genvar k = 0; k < TAPS; k++) begin : g_pe
    conv_pe #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_pe (
      .clk    (clk),
      .rst    (rst),
      .advance(strobes.advance),
      .weight (wChain[TAPS-1-k]),
      .xIn    (sampleLink[k]),
      .yIn    (sumLink[k+1]),
      .xOut   (sampleLink[k+1]),
      .yOut   (sumLink[k])
    );
  end

  assign result = sumLink[0];

  // R2: the newest loaded weight lands at the top of the chain
  a_r2_weight_entry: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftWeight |=> (wChain[TAPS-1] == $past(weightIn)));

  // R4: a sample leaves the last element one advance after entering it
  a_r4_sample_exit: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=> (sampleLink[TAPS] == $past(sampleLink[TAPS-1])));
endmodule

// File: rtl/conv_ctrl.sv
`timescale 1ns/1ps
module conv_ctrl import conv_pkg::*; #(
  parameter int TAPS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loadEn,
  input  logic         sampleValid,
  output convStrobes_t strobes,
  output logic         resultValid
);
  localparam int HIST_LEN = 2 * (TAPS - 1);

  logic [HIST_LEN-1:0] validHist;   // bit 0: previous advancing cycle
  logic                prevOk;

  always_comb begin
    strobes.advance     = !loadEn;
    strobes.shiftWeight = loadEn;
    strobes.takeSample  = !loadEn && sampleValid;
  end

  // Samples 2, 4, 6 ... advancing cycles back must all have been real
  always_comb begin
    prevOk = 1'b1;
    for (int j = 1; j < HIST_LEN; j += 2) prevOk = prevOk & validHist[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validHist   <= '0;
      resultValid <= 1'b0;
    end else if (loadEn) begin
      resultValid <= 1'b0;
    end else begin
      validHist   <= {validHist[HIST_LEN-2:0], sampleValid};
      resultValid <= sampleValid && prevOk;
    end
  end

  // R6: a valid result always follows an accepted sample
  a_r6_valid_cause: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> $past(sampleValid && !loadEn));

  // R3: nothing is flagged valid right after a load cycle
  a_r3_quiet_load: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> !resultValid);
endmodule

// File: rtl/conv_systolic.sv
`timescale 1ns/1ps
module conv_systolic import conv_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 20,
  parameter int TAPS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loadEn,
  input  logic signed [DATA_W-1:0] weightIn,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [SUM_W-1:0]  result,
  output logic                     resultValid
);
  convStrobes_t strobes;

  conv_ctrl #(.TAPS(TAPS)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .sampleValid(sampleValid),
    .strobes    (strobes),
    .resultValid(resultValid)
  );

  conv_datapath #(.DATA_W(DATA_W), .SUM_W(SUM_W), .TAPS(TAPS)) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .sampleIn(sampleIn),
    .weightIn(weightIn),
    .result  (result)
  );

  // R1: the cycle after reset shows a cleared output
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && !resultValid));

  // R3: the output sum is held through a load cycle
  a_r3_hold_result: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> $stable(result));
endmodule

// File: tb/test_conv_systolic.sv
`timescale 1ns/1ps
module test_conv_systolic;
  logic              clk = 1'b0;
  logic              rst = 1'b0;
  logic              loadEn = 1'b0;
  logic signed [7:0] weightIn = '0;
  logic              sampleValid = 1'b0;
  logic signed [7:0] sampleIn = '0;
  logic signed [19:0] result;
  logic              resultValid;

  int checks = 0;
  int fails  = 0;

  // Reference state
  int act;
  int wNow [4];          // wNow[j] = weight w(j+1)
  int inj  [1024];
  int vld  [1024];
  int wSnap[1024][4];
  int expRes;
  bit expVal;

  always #10 clk = ~clk;  // 20 ns period

  conv_systolic i_conv_systolic (
    .clk(clk), .rst(rst), .loadEn(loadEn), .weightIn(weightIn),
    .sampleValid(sampleValid), .sampleIn(sampleIn),
    .result(result), .resultValid(resultValid)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, actual, expected, $time);
    end
  endtask

  function automatic int injAt(input int n);
    return (n >= 0) ? inj[n] : 0;
  endfunction

  function automatic int vldAt(input int n);
    return (n >= 0) ? vld[n] : 0;
  endfunction

  function automatic int wAt(input int n, input int j);
    return (n >= 0) ? wSnap[n][j] : 0;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; loadEn = 1'b0; sampleValid = 1'b0; sampleIn = '0; weightIn = '0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    act = 0; expRes = 0; expVal = 1'b0;
    for (int j = 0; j < 4; j++) wNow[j] = 0;
    @(posedge clk); #2;
    check(result == 0, "R1", int'(result), 0);
    check(resultValid == 1'b0, "R1", int'(resultValid), 0);
  endtask

  // One clock: drive, update reference, compare
  task automatic step(input bit ld, input int w, input bit sv, input int x, input string req);
    int n;
    @(negedge clk);
    loadEn = ld; weightIn = 8'(w); sampleValid = sv; sampleIn = 8'(x);
    @(posedge clk); #2;
    if (ld) begin
      for (int j = 0; j < 3; j++) wNow[j] = wNow[j+1];
      wNow[3] = w;
      expVal = 1'b0;
    end else begin
      n = act;
      inj[n] = sv ? x : 0;
      vld[n] = sv ? 1 : 0;
      for (int j = 0; j < 4; j++) wSnap[n][j] = wNow[j];
      expRes = 0;
      for (int k = 0; k < 4; k++) expRes += wAt(n - k, 3 - k) * injAt(n - 2 * k);
      expVal = sv && vldAt(n - 2) == 1 && vldAt(n - 4) == 1 && vldAt(n - 6) == 1;
      act++;
    end
    check(int'(result) == expRes, req, int'(result), expRes);
    check(resultValid == expVal, req, int'(resultValid), int'(expVal));
  endtask

  task automatic loadWeights(input int a, input int b, input int c, input int d);
    step(1, a, 0, 0, "R2");
    step(1, b, 0, 0, "R2");
    step(1, c, 0, 0, "R2");
    step(1, d, 0, 0, "R2");
  endtask

  // R2: impulse shows w4, w3, w2, w1 two cycles apart
  task automatic testImpulse();
    loadWeights(3, 5, 7, 11);
    step(0, 0, 1, 1, "R2");
    check(int'(result) == 11, "R2", int'(result), 11);
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    check(int'(result) == 7, "R2", int'(result), 7);
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    check(int'(result) == 5, "R2", int'(result), 5);
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    check(int'(result) == 3, "R2", int'(result), 3);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R4");
  endtask

  // R5, R6: alternating ramp, first valid 7 cycles after first sample
  task automatic testRamp();
    int firstAt;
    int s[10];
    doReset();
    loadWeights(1, 2, 3, 4);
    firstAt = -1;
    for (int i = 0; i < 10; i++) s[i] = i + 1;
    for (int i = 0; i < 10; i++) begin
      step(0, 0, 1, s[i], "R5");
      if (resultValid && firstAt < 0) firstAt = 2 * i + 1;
      if (i >= 3)
        check(int'(result) == s[i-3] + 2 * s[i-2] + 3 * s[i-1] + 4 * s[i], "R5",
              int'(result), s[i-3] + 2 * s[i-2] + 3 * s[i-1] + 4 * s[i]);
      step(0, 0, 0, 99, "R7");
    end
    check(firstAt == 7, "R6", firstAt, 7);
  endtask

  // R8: signed extremes
  task automatic testSigned();
    doReset();
    loadWeights(-128, -128, -128, -128);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, -128, "R8");
      step(0, 0, 0, 0, "R8");
    end
    loadWeights(-128, 127, -1, 5);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1, (i % 2 == 0) ? 127 : -128, "R8");
      step(0, 0, 0, -77, "R8");
    end
  endtask

  // R3, R7: reload mid-stream with garbage on the sample pins
  task automatic testFreeze();
    int held;
    doReset();
    loadWeights(2, -3, 4, -5);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 10 * i - 20, "R4");
      step(0, 0, 0, 55, "R7");
    end
    step(0, 0, 1, 9, "R4");
    held = int'(result);
    step(1, 6, 1, 123, "R3");
    check(int'(result) == held, "R3", int'(result), held);
    check(resultValid == 1'b0, "R3", int'(resultValid), 0);
    step(1, 7, 1, -99, "R3");
    step(1, 8, 0, 44, "R3");
    check(int'(result) == held, "R3", int'(result), held);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 66, "R7");
      step(0, 0, 1, i - 3, "R4");
    end
  endtask

  // R4, R6: samples on every cycle (no idle slots)
  task automatic testDense();
    doReset();
    loadWeights(1, -1, 2, -2);
    for (int i = 0; i < 12; i++) step(0, 0, 1, 3 * i - 15, "R4");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 17, "R6");
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    testImpulse();
    testRamp();
    testSigned();
    testFreeze();
    testDense();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule